// File: doc/BRIEF.md
# Register-Mapped Network Port Interface

This block sits between the operand/result path of a simple in-order pipeline and a set of network queues. A small window of register numbers is claimed by the networks instead of by register storage. When an instruction names one of those numbers as a source, the operand comes from the head word of the matching network input queue, and that word is consumed. When it names one as its destination, the instruction's result goes into the matching network output queue instead of into the register file.

The operand multiplexing, the issue stall and the queue pop/push strobes are all combinational in the cycle an instruction is presented. An external execution stage can therefore take a network word as an operand and return its result to a network in the same instruction. Each network has a 4-entry input queue, filled by the router side, and a 4-entry output queue, drained by the router side.

Top module: `netreg_port`

## Requirements
- R1: After reset every input queue is empty and ready to accept (`net_in_ready` all ones), no output queue holds a word (`net_out_valid` all zeros), and `stall` is low while `iss_valid` is low.
- R2: Register numbers 24, 25, 26 and 27 select networks 0, 1, 2 and 3 in that order. Any other source number passes `rf_a_data`/`rf_b_data` through to `op_a`/`op_b` unchanged.
- R3: Reading a mapped source register returns the head word of that network's input queue on the operand port in the same cycle. Issue consumes that word, so successive reads see the words in arrival order.
- R4: If both sources name the same mapped register, both operands carry the same head word and the queue advances by exactly one word.
- R5: While any named input queue is empty, `stall` is high and `issue_fire` is low. Nothing is popped or pushed, `rf_we` stays low, and no queued word is lost.
- R6: Issuing with a mapped destination pushes `res_data` into that network's output queue, where it appears on `net_out_valid`/`net_out_data` from the next cycle. `rf_we` stays low for that instruction.
- R7: An instruction whose mapped destination queue already holds 4 words stalls until the router side drains one. Output words leave in the order they were written.
- R8: One instruction may read one network and write another. The consumed operand and the produced result move through the queues in that single issue.
- R9: An input queue holds up to 4 words. `net_in_ready` is low when it is full, a word offered while it is full is not stored, and stored words are read back in arrival order.
- R10: Issuing with an unmapped destination raises `rf_we` in the issue cycle and pushes nothing to any network.
- R11: A source or destination whose enable is low is ignored even if its number is mapped. It causes no stall, no pop and no push, and a disabled source operand takes the register-file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| src_a_en | input | 1 | Source A is used |
| src_a_idx | input | 5 | Source A register number |
| src_b_en | input | 1 | Source B is used |
| src_b_idx | input | 5 | Source B register number |
| dst_en | input | 1 | Instruction writes a destination |
| dst_idx | input | 5 | Destination register number |
| rf_a_data | input | 32 | Register file value for source A |
| rf_b_data | input | 32 | Register file value for source B |
| res_data | input | 32 | Result of the presented instruction |
| op_a | output | 32 | Operand A to execution |
| op_b | output | 32 | Operand B to execution |
| stall | output | 1 | Issue is held this cycle |
| issue_fire | output | 1 | Instruction issues this cycle |
| rf_we | output | 1 | Write enable to register storage |
| net_in_valid | input | 4 | Router offers a word, one bit per network |
| net_in_data | input | 128 | Offered words, network n in bits [32n+31:32n] |
| net_in_ready | output | 4 | Input queue has room |
| net_out_valid | output | 4 | Output queue holds a word |
| net_out_data | output | 128 | Output queue head words, network n in bits [32n+31:32n] |
| net_out_ready | input | 4 | Router takes the head word |

## Verification
`op_a`, `op_b`, `stall`, `issue_fire` and `rf_we` are combinational and due in the same cycle the instruction is presented. The bench therefore drives inputs just after a falling edge and samples these outputs 1 ns later, before the next rising edge. Queue state moves on the rising edge that issues the instruction or accepts a router word. A word offered to an input queue can be read by an instruction presented in the following cycle. A word written to an output queue shows on `net_out_valid`/`net_out_data` in the cycle after the issuing edge, and the bench samples it there. Queue order and the single pop on a duplicated source are confirmed by reading back the following word on a later issue, not by looking inside the design.

// File: rtl/netreg_pkg.sv
`timescale 1ns/1ps
package netreg_pkg;

    localparam int REG_IDX_W      = 5;
    localparam int DATA_W_DEF     = 32;
    localparam int NUM_NET_DEF    = 4;
    localparam int FIFO_DEPTH_DEF = 4;
    localparam int MAP_BASE_DEF   = 24;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    // One register reference of an instruction: enable plus number
    typedef struct packed {
        logic     en;
        reg_idx_t idx;
    } reg_ref_t;

    function automatic logic idx_in_window(input reg_idx_t idx, input int base, input int count);
        return (int'(idx) >= base) && (int'(idx) < base + count);
    endfunction

endpackage

// File: rtl/netreg_fifo.sv
`timescale 1ns/1ps
module netreg_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  cnt;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    assign head  = mem[rd_ptr];
    assign full  = (cnt == FULL_CNT);
    assign empty = (cnt == '0);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
    // R9
    count_track_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/netreg_decode.sv
`timescale 1ns/1ps
module netreg_decode
    import netreg_pkg::*;
#(
    parameter int NUM_NET  = 4,
    parameter int MAP_BASE = 24
) (
    input  reg_ref_t           r_i,
    output logic               hit_o,
    output logic [NUM_NET-1:0] sel_o
);
    always_comb begin
        hit_o = r_i.en && idx_in_window(r_i.idx, MAP_BASE, NUM_NET);
        sel_o = '0;
        for (int n = 0; n < NUM_NET; n++) begin
            if (r_i.en && (int'(r_i.idx) == MAP_BASE + n)) sel_o[n] = 1'b1;
        end
    end
endmodule

// File: rtl/netreg_issue.sv
`timescale 1ns/1ps
module netreg_issue #(
    parameter int NUM_NET = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               iss_valid,
    input  logic [NUM_NET-1:0] pop_need,
    input  logic [NUM_NET-1:0] push_need,
    input  logic [NUM_NET-1:0] in_empty,
    input  logic [NUM_NET-1:0] out_full,
    input  logic               dst_en,
    input  logic               dst_hit,
    output logic               stall,
    output logic               fire,
    output logic [NUM_NET-1:0] pop,
    output logic [NUM_NET-1:0] push,
    output logic               rf_we
);
    logic blocked;

    always_comb begin
        blocked = (|(pop_need & in_empty)) || (|(push_need & out_full));
        stall   = iss_valid && blocked;
        fire    = iss_valid && !blocked;
        pop     = pop_need  & {NUM_NET{fire}};
        push    = push_need & {NUM_NET{fire}};
        rf_we   = fire && dst_en && !dst_hit;
    end

    // R5
    pop_on_empty_chk: assert property (@(posedge clk) disable iff (rst) !(|(pop & in_empty)));
    // R7
    push_on_full_chk: assert property (@(posedge clk) disable iff (rst) !(|(push & out_full)));
    // R6
    mapped_dst_rf_chk: assert property (@(posedge clk) disable iff (rst) rf_we |-> !dst_hit);

endmodule

// File: rtl/netreg_port.sv
`timescale 1ns/1ps
module netreg_port
    import netreg_pkg::*;
#(
    parameter int DATA_W     = DATA_W_DEF,
    parameter int NUM_NET    = NUM_NET_DEF,
    parameter int FIFO_DEPTH = FIFO_DEPTH_DEF,
    parameter int MAP_BASE   = MAP_BASE_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      iss_valid,
    input  logic                      src_a_en,
    input  logic [REG_IDX_W-1:0]      src_a_idx,
    input  logic                      src_b_en,
    input  logic [REG_IDX_W-1:0]      src_b_idx,
    input  logic                      dst_en,
    input  logic [REG_IDX_W-1:0]      dst_idx,
    input  logic [DATA_W-1:0]         rf_a_data,
    input  logic [DATA_W-1:0]         rf_b_data,
    input  logic [DATA_W-1:0]         res_data,
    output logic [DATA_W-1:0]         op_a,
    output logic [DATA_W-1:0]         op_b,
    output logic                      stall,
    output logic                      issue_fire,
    output logic                      rf_we,
    input  logic [NUM_NET-1:0]        net_in_valid,
    input  logic [NUM_NET*DATA_W-1:0] net_in_data,
    output logic [NUM_NET-1:0]        net_in_ready,
    output logic [NUM_NET-1:0]        net_out_valid,
    output logic [NUM_NET*DATA_W-1:0] net_out_data,
    input  logic [NUM_NET-1:0]        net_out_ready
);
    reg_ref_t ref_a, ref_b, ref_d;
    logic a_hit, b_hit, d_hit;
    logic [NUM_NET-1:0] a_sel, b_sel, d_sel;
    logic [NUM_NET-1:0] pop, push;
    logic [NUM_NET-1:0] in_full, in_empty, out_full, out_empty;
    logic [DATA_W-1:0]  in_head  [NUM_NET];
    logic [DATA_W-1:0]  out_head [NUM_NET];

    assign ref_a = '{en: src_a_en, idx: src_a_idx};
    assign ref_b = '{en: src_b_en, idx: src_b_idx};
    assign ref_d = '{en: dst_en,   idx: dst_idx};

    netreg_decode #(.NUM_NET(NUM_NET), .MAP_BASE(MAP_BASE)) u_dec_a (.r_i(ref_a), .hit_o(a_hit), .sel_o(a_sel));
    netreg_decode #(.NUM_NET(NUM_NET), .MAP_BASE(MAP_BASE)) u_dec_b (.r_i(ref_b), .hit_o(b_hit), .sel_o(b_sel));
    netreg_decode #(.NUM_NET(NUM_NET), .MAP_BASE(MAP_BASE)) u_dec_d (.r_i(ref_d), .hit_o(d_hit), .sel_o(d_sel));

    netreg_issue #(.NUM_NET(NUM_NET)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (iss_valid),
        .pop_need  (a_sel | b_sel),
        .push_need (d_sel),
        .in_empty  (in_empty),
        .out_full  (out_full),
        .dst_en    (dst_en),
        .dst_hit   (d_hit),
        .stall     (stall),
        .fire      (issue_fire),
        .pop       (pop),
        .push      (push),
        .rf_we     (rf_we)
    );

    for (genvar n = 0; n < NUM_NET; n++) begin : g_net
        netreg_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_in_q (
            .clk       (clk),
            .rst       (rst),
            .push      (net_in_valid[n] & ~in_full[n]),
            .push_data (net_in_data[n*DATA_W +: DATA_W]),
            .pop       (pop[n]),
            .head      (in_head[n]),
            .full      (in_full[n]),
            .empty     (in_empty[n])
        );
        netreg_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_out_q (
            .clk       (clk),
            .rst       (rst),
            .push      (push[n]),
            .push_data (res_data),
            .pop       (net_out_ready[n] & ~out_empty[n]),
            .head      (out_head[n]),
            .full      (out_full[n]),
            .empty     (out_empty[n])
        );
        assign net_out_data[n*DATA_W +: DATA_W] = out_head[n];
    end

    assign net_in_ready  = ~in_full;
    assign net_out_valid = ~out_empty;

    // Operand forwarding: a mapped source takes its network's head word
    always_comb begin
        op_a = a_hit ? '0 : rf_a_data;
        op_b = b_hit ? '0 : rf_b_data;
        for (int n = 0; n < NUM_NET; n++) begin
            if (a_sel[n]) op_a = op_a | in_head[n];
            if (b_sel[n]) op_b = op_b | in_head[n];
        end
    end

    // R4
    single_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (a_hit && b_hit && (src_a_idx == src_b_idx)) |-> ($countones(pop) <= 1));

endmodule

// File: tb/netreg_port_tb.sv
`timescale 1ns/1ps
module netreg_port_tb;
    localparam int NN = 4;

    logic clk = 1'b0;
    logic rst;
    logic iss_valid, src_a_en, src_b_en, dst_en;
    logic [4:0] src_a_idx, src_b_idx, dst_idx;
    logic [31:0] rf_a_data, rf_b_data, res_data, op_a, op_b;
    logic stall, issue_fire, rf_we;
    logic [NN-1:0] net_in_valid, net_in_ready, net_out_valid, net_out_ready;
    logic [NN*32-1:0] net_in_data, net_out_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    netreg_port u_dut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid),
        .src_a_en(src_a_en), .src_a_idx(src_a_idx),
        .src_b_en(src_b_en), .src_b_idx(src_b_idx),
        .dst_en(dst_en), .dst_idx(dst_idx),
        .rf_a_data(rf_a_data), .rf_b_data(rf_b_data), .res_data(res_data),
        .op_a(op_a), .op_b(op_b), .stall(stall), .issue_fire(issue_fire), .rf_we(rf_we),
        .net_in_valid(net_in_valid), .net_in_data(net_in_data), .net_in_ready(net_in_ready),
        .net_out_valid(net_out_valid), .net_out_data(net_out_data), .net_out_ready(net_out_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive_iss(input logic ae, input logic [4:0] ai, input logic be,
                             input logic [4:0] bi, input logic de, input logic [4:0] di);
        @(negedge clk);
        iss_valid = 1'b1;
        src_a_en = ae; src_a_idx = ai;
        src_b_en = be; src_b_idx = bi;
        dst_en = de;   dst_idx = di;
        #1;
    endtask

    task automatic release_iss();
        @(posedge clk);
        #1;
        iss_valid = 1'b0; src_a_en = 1'b0; src_b_en = 1'b0; dst_en = 1'b0;
    endtask

    task automatic push_in(input int n, input logic [31:0] d);
        @(negedge clk);
        net_in_valid[n] = 1'b1;
        net_in_data[n*32 +: 32] = d;
        @(posedge clk);
        #1;
        net_in_valid[n] = 1'b0;
    endtask

    task automatic drain_out(input int n, input logic [31:0] exp, input string tag);
        @(negedge clk);
        #1;
        chk({tag, " out valid"}, 32'(net_out_valid[n]), 32'd1);
        chk({tag, " out data"}, net_out_data[n*32 +: 32], exp);
        net_out_ready[n] = 1'b1;
        @(posedge clk);
        #1;
        net_out_ready[n] = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk("R1 in_ready", 32'(net_in_ready), 32'hF);
        chk("R1 out_valid", 32'(net_out_valid), 32'h0);
        chk("R1 stall", 32'(stall), 32'h0);
    endtask

    task automatic t_passthrough();
        rf_a_data = 32'h111; rf_b_data = 32'h222;
        drive_iss(1, 5'd3, 1, 5'd5, 1, 5'd7);
        chk("R2 op_a rf", op_a, 32'h111);
        chk("R2 op_b rf", op_b, 32'h222);
        chk("R10 fire", 32'(issue_fire), 32'd1);
        chk("R10 rf_we", 32'(rf_we), 32'd1);
        release_iss();
        @(negedge clk); #1;
        chk("R10 no push", 32'(net_out_valid), 32'h0);
    endtask

    task automatic t_read();
        push_in(1, 32'hA0);
        push_in(1, 32'hA1);
        rf_b_data = 32'h333;
        drive_iss(1, 5'd25, 1, 5'd2, 0, 5'd0);
        chk("R3 first head", op_a, 32'hA0);
        chk("R2 op_b rf", op_b, 32'h333);
        chk("R3 no stall", 32'(stall), 32'd0);
        release_iss();
        drive_iss(1, 5'd25, 0, 5'd0, 0, 5'd0);
        chk("R3 second head", op_a, 32'hA1);
        release_iss();
        drive_iss(1, 5'd25, 0, 5'd0, 0, 5'd0);
        chk("R5 drained stall", 32'(stall), 32'd1);
        release_iss();
    endtask

    task automatic t_dup();
        push_in(2, 32'hB0);
        push_in(2, 32'hB1);
        drive_iss(1, 5'd26, 1, 5'd26, 0, 5'd0);
        chk("R4 op_a", op_a, 32'hB0);
        chk("R4 op_b", op_b, 32'hB0);
        release_iss();
        drive_iss(1, 5'd26, 0, 5'd0, 0, 5'd0);
        chk("R4 one pop", op_a, 32'hB1);
        release_iss();
    endtask

    task automatic t_stall_empty();
        drive_iss(1, 5'd27, 0, 5'd0, 1, 5'd4);
        chk("R5 stall", 32'(stall), 32'd1);
        chk("R5 no fire", 32'(issue_fire), 32'd0);
        chk("R5 no rf_we", 32'(rf_we), 32'd0);
        release_iss();
        res_data = 32'hDEAD;
        drive_iss(1, 5'd27, 0, 5'd0, 1, 5'd24);
        chk("R5 stall mapped dst", 32'(stall), 32'd1);
        release_iss();
        @(negedge clk); #1;
        chk("R5 no push on stall", 32'(net_out_valid), 32'h0);
        push_in(3, 32'hC0);
        drive_iss(1, 5'd27, 0, 5'd0, 1, 5'd4);
        chk("R5 resumed stall", 32'(stall), 32'd0);
        chk("R5 word kept", op_a, 32'hC0);
        chk("R10 rf_we", 32'(rf_we), 32'd1);
        release_iss();
    endtask

    task automatic t_write_full();
        for (int i = 0; i < 4; i++) begin
            res_data = 32'hD0 + 32'(i);
            drive_iss(0, 5'd0, 0, 5'd0, 1, 5'd24);
            chk("R6 no stall", 32'(stall), 32'd0);
            chk("R6 no rf_we", 32'(rf_we), 32'd0);
            release_iss();
            if (i == 0) begin
                @(negedge clk); #1;
                chk("R6 out valid", 32'(net_out_valid[0]), 32'd1);
                chk("R6 out data", net_out_data[31:0], 32'hD0);
            end
        end
        res_data = 32'hD4;
        drive_iss(0, 5'd0, 0, 5'd0, 1, 5'd24);
        chk("R7 full stall", 32'(stall), 32'd1);
        release_iss();
        drain_out(0, 32'hD0, "R7 drain0");
        drive_iss(0, 5'd0, 0, 5'd0, 1, 5'd24);
        chk("R7 resumed", 32'(stall), 32'd0);
        release_iss();
        for (int i = 1; i < 5; i++) drain_out(0, 32'hD0 + 32'(i), "R7 order");
    endtask

    task automatic t_both();
        push_in(1, 32'hE0);
        drive_iss(1, 5'd25, 0, 5'd0, 1, 5'd26);
        chk("R8 operand", op_a, 32'hE0);
        chk("R8 no stall", 32'(stall), 32'd0);
        res_data = 32'hE0 ^ 32'hFFFF;
        #1;
        release_iss();
        drain_out(2, 32'hE0 ^ 32'hFFFF, "R8 result");
        drive_iss(1, 5'd25, 0, 5'd0, 0, 5'd0);
        chk("R8 consumed", 32'(stall), 32'd1);
        release_iss();
    endtask

    task automatic t_in_full();
        for (int i = 0; i < 4; i++) push_in(0, 32'hF0 + 32'(i));
        @(negedge clk); #1;
        chk("R9 not ready", 32'(net_in_ready[0]), 32'd0);
        push_in(0, 32'hF4);
        for (int i = 0; i < 4; i++) begin
            drive_iss(1, 5'd24, 0, 5'd0, 0, 5'd0);
            chk("R9 order", op_a, 32'hF0 + 32'(i));
            release_iss();
        end
        drive_iss(1, 5'd24, 0, 5'd0, 0, 5'd0);
        chk("R9 extra dropped", 32'(stall), 32'd1);
        release_iss();
    endtask

    task automatic t_disabled();
        rf_a_data = 32'h777; rf_b_data = 32'h888; res_data = 32'h999;
        drive_iss(0, 5'd27, 0, 5'd24, 0, 5'd24);
        chk("R11 no stall", 32'(stall), 32'd0);
        chk("R11 op_a rf", op_a, 32'h777);
        chk("R11 op_b rf", op_b, 32'h888);
        chk("R11 no rf_we", 32'(rf_we), 32'd0);
        release_iss();
        @(negedge clk); #1;
        chk("R11 no push", 32'(net_out_valid), 32'h0);
    endtask

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        iss_valid = 0; src_a_en = 0; src_b_en = 0; dst_en = 0;
        src_a_idx = '0; src_b_idx = '0; dst_idx = '0;
        rf_a_data = '0; rf_b_data = '0; res_data = '0;
        net_in_valid = '0; net_in_data = '0; net_out_ready = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_passthrough();
        t_read();
        t_dup();
        t_stall_empty();
        t_write_full();
        t_both();
        t_in_full();
        t_disabled();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule